// File: doc/BRIEF.md
# UART Modem Handshake Control and Local Loopback

This block keeps the modem control byte of a serial port controller and turns it into the four active-low handshake pins: data terminal ready, request to send and two general-purpose auxiliary outputs. A control bit written as 1 pulls its pin low, and a bit written as 0 leaves the pin high. The CPU writes the byte through a simple write strobe. It reads the byte back at any time on a combinational read bus.

A fifth control bit selects a diagnostic loopback. In loopback the external serial output idles at marking (logic 1), and the external serial input and modem status pins are disconnected. The transmitter's serial stream goes straight to the receiver input. The four handshake pins are parked inactive high, and the four control bits are fed back internally as the modem status seen by the rest of the port. This lets software test the transmit, receive and status paths with no cable attached. Outside loopback, the serial lines pass straight through. The active-low modem status pins are inverted into active-high status for the receiver side.

Top module: `uart_mdm_ctl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the control byte reads 0x00. All four handshake pins are high and loopback is off.
- R2: With loopback off, `dtr_n` equals the inverse of control bit 0.
- R3: With loopback off, `rts_n` equals the inverse of control bit 1.
- R4: With loopback off, `out1_n` equals the inverse of control bit 2 and `out2_n` equals the inverse of control bit 3.
- R5: A write stores `wdata[4:0]`. From the next cycle, `rdata` returns those five bits, and bits 7:5 always read as 0.
- R6: With loopback off, `ext_sout` follows `tx_sout` and `rx_sin` follows `ext_sin`.
- R7: With loopback on (control bit 4 = 1), `ext_sout` is held at 1 and `rx_sin` follows `tx_sout`. `ext_sin` has no effect.
- R8: With loopback on, `dtr_n`, `rts_n`, `out1_n` and `out2_n` are all high, whatever control bits 3:0 hold.
- R9: With loopback on, `stat_dsr`, `stat_cts`, `stat_ri` and `stat_dcd` equal control bits 0, 1, 2 and 3 respectively. The external modem pins have no effect.
- R10: With loopback off, each of `stat_dsr`, `stat_cts`, `stat_ri` and `stat_dcd` is the inverse of its active-low pin `dsr_n`, `cts_n`, `ri_n` or `dcd_n`.
- R11: While `wr_en` is low, the stored control byte does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read-back of the control byte, bits 7:5 zero |
| tx_sout | input | 1 | Serial stream from the transmitter shifter |
| ext_sin | input | 1 | Serial input pin |
| dsr_n | input | 1 | Data set ready pin, active low |
| cts_n | input | 1 | Clear to send pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| dtr_n | output | 1 | Data terminal ready pin, active low |
| rts_n | output | 1 | Request to send pin, active low |
| out1_n | output | 1 | Auxiliary output 1, active low |
| out2_n | output | 1 | Auxiliary output 2, active low |
| ext_sout | output | 1 | Serial output pin |
| rx_sin | output | 1 | Serial stream to the receiver shifter |
| stat_dsr | output | 1 | Data set ready status to the status logic |
| stat_cts | output | 1 | Clear to send status to the status logic |
| stat_ri | output | 1 | Ring indicator status to the status logic |
| stat_dcd | output | 1 | Carrier detect status to the status logic |

## Verification
The bench writes control bytes with the upper three bits set. A design that stored or echoed them would fail the read-back, and one that decoded the loopback bit from the wrong position would route the serial lines wrongly. Inside loopback it uses asymmetric bit patterns, so a swapped internal mapping such as RTS to DSR shows up as a wrong status bit. It also toggles the external serial and modem inputs to catch any leak from the pins while loopback is on. It leaves loopback with nonzero control bits, to catch pins that stay parked high or are not inverted. It checks reset and the write strobe, so that a design that keeps stale bits or latches writes without the strobe is reported.

// File: rtl/uart_mdm_ctl_pkg.sv
package uart_mdm_ctl_pkg;

    localparam int DATA_W   = 8;
    localparam int N_HS     = 4;
    localparam int LOOP_POS = 4;
    localparam int CTL_W    = LOOP_POS + 1;

    // Stored control field: loop at bit 4, handshake bits 3:0
    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mcr_t;

    // Modem status delivered to the status logic, active high
    typedef struct packed {
        logic dcd;
        logic ri;
        logic cts;
        logic dsr;
    } mdm_stat_t;

    function automatic logic [DATA_W-1:0] mcr_to_bus(input mcr_t m);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CTL_W-1:0] = m;
        return v;
    endfunction

    function automatic mcr_t bus_to_mcr(input logic [DATA_W-1:0] d);
        return mcr_t'(d[CTL_W-1:0]);
    endfunction

    function automatic logic [N_HS-1:0] hs_bits(input mcr_t m);
        return {m.out2, m.out1, m.rts, m.dtr};
    endfunction

endpackage

// File: rtl/uart_mdm_ctl_reg.sv
module uart_mdm_ctl_reg
    import uart_mdm_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output mcr_t              q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= bus_to_mcr(wdata);
        end
    end
endmodule

// File: rtl/uart_mdm_ctl_pins.sv
module uart_mdm_ctl_pins #(
    parameter int N = 4
) (
    input  logic [N-1:0] ctl,
    input  logic         loop,
    output logic [N-1:0] pin_n
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        assign pin_n[i] = loop ? 1'b1 : ~ctl[i];
    end
endmodule

// File: rtl/uart_mdm_ctl_route.sv
module uart_mdm_ctl_route
    import uart_mdm_ctl_pkg::*;
(
    input  logic            loop,
    input  logic [N_HS-1:0] ctl,
    input  logic            tx_sout,
    input  logic            ext_sin,
    input  logic [N_HS-1:0] pin_stat_n,
    output logic            ext_sout,
    output logic            rx_sin,
    output mdm_stat_t       stat
);
    always_comb begin
        if (loop) begin
            ext_sout = 1'b1;
            rx_sin   = tx_sout;
            stat     = mdm_stat_t'(ctl);
        end else begin
            ext_sout = tx_sout;
            rx_sin   = ext_sin;
            stat     = mdm_stat_t'(~pin_stat_n);
        end
    end
endmodule

// File: rtl/uart_mdm_ctl.sv
module uart_mdm_ctl
    import uart_mdm_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tx_sout,
    input  logic              ext_sin,
    input  logic              dsr_n,
    input  logic              cts_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              out1_n,
    output logic              out2_n,
    output logic              ext_sout,
    output logic              rx_sin,
    output logic              stat_dsr,
    output logic              stat_cts,
    output logic              stat_ri,
    output logic              stat_dcd
);
    mcr_t            mcr_q;
    logic [N_HS-1:0] hs;
    logic [N_HS-1:0] hs_pin_n;
    mdm_stat_t       stat;

    uart_mdm_ctl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .wdata (wdata),
        .q     (mcr_q)
    );

    assign hs    = hs_bits(mcr_q);
    assign rdata = mcr_to_bus(mcr_q);

    uart_mdm_ctl_pins #(.N(N_HS)) u_pins (
        .ctl   (hs),
        .loop  (mcr_q.loop),
        .pin_n (hs_pin_n)
    );

    assign {out2_n, out1_n, rts_n, dtr_n} = hs_pin_n;

    uart_mdm_ctl_route u_route (
        .loop       (mcr_q.loop),
        .ctl        (hs),
        .tx_sout    (tx_sout),
        .ext_sin    (ext_sin),
        .pin_stat_n ({dcd_n, ri_n, cts_n, dsr_n}),
        .ext_sout   (ext_sout),
        .rx_sin     (rx_sin),
        .stat       (stat)
    );

    assign stat_dsr = stat.dsr;
    assign stat_cts = stat.cts;
    assign stat_ri  = stat.ri;
    assign stat_dcd = stat.dcd;
endmodule

// File: rtl/uart_mdm_ctl_chk.sv
module uart_mdm_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       tx_sout,
    input logic       ext_sin,
    input logic       dsr_n,
    input logic       cts_n,
    input logic       ri_n,
    input logic       dcd_n,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       out1_n,
    input logic       out2_n,
    input logic       ext_sout,
    input logic       rx_sin,
    input logic       stat_dsr,
    input logic       stat_cts,
    input logic       stat_ri,
    input logic       stat_dcd
);
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (rdata == 8'h00));

    p_dtr_inv_r2: assert property (@(posedge clk) disable iff (rst)
        !rdata[4] |-> (dtr_n == !rdata[0]));

    p_rts_inv_r3: assert property (@(posedge clk) disable iff (rst)
        !rdata[4] |-> (rts_n == !rdata[1]));

    p_aux_inv_r4: assert property (@(posedge clk) disable iff (rst)
        !rdata[4] |-> (out1_n == !rdata[2] && out2_n == !rdata[3]));

    p_readback_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rdata == {3'b000, $past(wdata[4:0])}));

    p_pass_r6: assert property (@(posedge clk) disable iff (rst)
        !rdata[4] |-> (ext_sout == tx_sout && rx_sin == ext_sin));

    p_loop_serial_r7: assert property (@(posedge clk) disable iff (rst)
        rdata[4] |-> (ext_sout && rx_sin == tx_sout));

    p_loop_pins_r8: assert property (@(posedge clk) disable iff (rst)
        rdata[4] |-> (dtr_n && rts_n && out1_n && out2_n));

    p_loop_stat_r9: assert property (@(posedge clk) disable iff (rst)
        rdata[4] |-> ({stat_dcd, stat_ri, stat_cts, stat_dsr} == rdata[3:0]));

    p_norm_stat_r10: assert property (@(posedge clk) disable iff (rst)
        !rdata[4] |-> ({stat_dcd, stat_ri, stat_cts, stat_dsr} == ~{dcd_n, ri_n, cts_n, dsr_n}));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rdata));
endmodule

bind uart_mdm_ctl uart_mdm_ctl_chk chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .tx_sout(tx_sout), .ext_sin(ext_sin),
    .dsr_n(dsr_n), .cts_n(cts_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
    .ext_sout(ext_sout), .rx_sin(rx_sin),
    .stat_dsr(stat_dsr), .stat_cts(stat_cts), .stat_ri(stat_ri), .stat_dcd(stat_dcd)
);

// File: tb/uart_mdm_ctl_tb_top.sv
module uart_mdm_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       tx_sout, ext_sin, dsr_n, cts_n, ri_n, dcd_n;
    logic       dtr_n, rts_n, out1_n, out2_n, ext_sout, rx_sin;
    logic       stat_dsr, stat_cts, stat_ri, stat_dcd;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    uart_mdm_ctl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .tx_sout(tx_sout), .ext_sin(ext_sin),
        .dsr_n(dsr_n), .cts_n(cts_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
        .ext_sout(ext_sout), .rx_sin(rx_sin),
        .stat_dsr(stat_dsr), .stat_cts(stat_cts), .stat_ri(stat_ri), .stat_dcd(stat_dcd)
    );

    // Entry: wdata[23:16] tx[15] sin[14] {dsr_n,cts_n,ri_n,dcd_n}[13:10]
    //        expected {dtr_n,rts_n,out1_n,out2_n}[9:6] ext_sout[5] rx_sin[4]
    //        {dsr,cts,ri,dcd}[3:0]
    localparam int NV = 8;
    localparam logic [23:0] VEC [NV] = '{
        {8'h00, 1'b0, 1'b1, 4'b1111, 4'b1111, 1'b0, 1'b1, 4'b0000},
        {8'h01, 1'b1, 1'b0, 4'b0000, 4'b0111, 1'b1, 1'b0, 4'b1111},
        {8'h0A, 1'b0, 1'b0, 4'b1010, 4'b1010, 1'b0, 1'b0, 4'b0101},
        {8'hEF, 1'b1, 1'b1, 4'b0110, 4'b0000, 1'b1, 1'b1, 4'b1001},
        {8'h10, 1'b0, 1'b1, 4'b0000, 4'b1111, 1'b1, 1'b0, 4'b0000},
        {8'h15, 1'b1, 1'b0, 4'b1111, 4'b1111, 1'b1, 1'b1, 4'b1010},
        {8'hFA, 1'b0, 1'b1, 4'b1010, 4'b1111, 1'b1, 1'b0, 4'b0101},
        {8'h0C, 1'b1, 1'b0, 4'b0101, 4'b1100, 1'b1, 1'b0, 4'b1010}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] outs();
        return {dtr_n, rts_n, out1_n, out2_n, ext_sout, rx_sin,
                stat_dsr, stat_cts, stat_ri, stat_dcd};
    endfunction

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wdata = 8'h00;
        tx_sout = 1'b0; ext_sin = 1'b1;
        {dsr_n, cts_n, ri_n, dcd_n} = 4'b1111;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rdata", {24'd0, rdata}, 32'h00);
        check("R1 pins", {28'd0, dtr_n, rts_n, out1_n, out2_n}, 32'hF);
        check("R1 loop off", {30'd0, ext_sout, rx_sin}, {30'd0, tx_sout, ext_sin});
        rst = 1'b0;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            tx_sout = VEC[i][15];
            ext_sin = VEC[i][14];
            {dsr_n, cts_n, ri_n, dcd_n} = VEC[i][13:10];
            write_byte(VEC[i][23:16]);
            check("R5 readback", {24'd0, rdata}, {24'd0, VEC[i][23:16] & 8'h1F});
            check("R2/R3/R4/R8 pins", {28'd0, outs()[9:6]}, {28'd0, VEC[i][9:6]});
            check("R6/R7 serial", {30'd0, outs()[5:4]}, {30'd0, VEC[i][5:4]});
            check("R9/R10 status", {28'd0, outs()[3:0]}, {28'd0, VEC[i][3:0]});
        end

        // R7 and R9: external inputs toggled in loopback have no effect
        write_byte(8'h13);
        tx_sout = 1'b1;
        for (int k = 0; k < 4; k++) begin
            ext_sin = k[0];
            {dsr_n, cts_n, ri_n, dcd_n} = 4'(k * 5);
            @(negedge clk);
            check("R7 sin ignored", {30'd0, ext_sout, rx_sin}, 32'h3);
            check("R9 pins ignored", {28'd0, stat_dsr, stat_cts, stat_ri, stat_dcd}, 32'hC);
        end

        // R11: no write without the strobe
        wdata = 8'h0F;
        repeat (3) @(negedge clk);
        check("R11 hold", {24'd0, rdata}, 32'h13);

        // R2 single bit after leaving loopback
        write_byte(8'h01);
        check("R2 dtr only", {28'd0, dtr_n, rts_n, out1_n, out2_n}, 32'h7);
        check("R6 pass", {30'd0, ext_sout, rx_sin}, {30'd0, tx_sout, ext_sin});

        // R1: synchronous reset clears a loaded value
        write_byte(8'h1F);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears", {24'd0, rdata}, 32'h00);
        check("R1 pins high", {28'd0, dtr_n, rts_n, out1_n, out2_n}, 32'hF);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {24'd0, rdata}, 32'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule